// File: doc/BRIEF.md
# Tiled Burst Address Generator

This block is the head of an input path that feeds a chain of tile distributors in a matrix engine. After a start pulse it walks six nested loop counters. At each step it places one memory word address on a request port with a valid/ready handshake. Every word carries eight packed matrix elements. The addresses come in the order that the distributor chain expects for a 64x64 operand.

The loop order, from the outermost loop to the innermost, is: outer tile index `t0` (0..3), middle tile index `t1` (0..3), inner tile index `t2` (0..3), distributor slice `s` (0..1), row `r` (0..7), and packed column `c` (0..1). The address is a fixed weighted sum of these counters. `t1` has a weight of zero, so the tiles are fetched again for every value of `t1`. The counters move only when a request is accepted, so the port can issue one address per cycle. The words that memory returns go through a combinational pass-through stream to the chain.

Top module: `tbag_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_valid_o` and `done_o` are 0.
- R2: A `start_i` pulse while idle (neither requesting nor signalling done) raises `req_valid_o` in the next cycle. Without a start, `req_valid_o` stays 0.
- R3: The k-th accepted address (k counted from 0) equals 128*t0 + 64*s + 8*r + 2*t2 + c. The counters are unpacked from k with `c` in the least significant place, then `r`, `s`, `t2`, `t1` and `t0`, using radices 2, 8, 2, 4, 4 and 4.
- R4: While `req_valid_o` is 1 and `req_ready_i` is 0, the request stays valid and the address does not change in the next cycle.
- R5: Exactly 2048 addresses are accepted per run. In the cycle after the last accept, `req_valid_o` is 0 and `done_o` is 1, and `done_o` is 1 for that single cycle only.
- R6: A `start_i` pulse during a run is ignored, and the address sequence continues without restarting.
- R7: Within one value of `t0`, the 128 addresses issued for each value of `t1` are identical.
- R8: The data path is combinational and independent of the sequencer: `dist_data_o` = `rd_data_i`, `dist_valid_o` = `rd_valid_i`, and `rd_ready_o` = `dist_ready_i`.
- R9: With `req_ready_i` held at 1, one address is accepted every cycle, and a run takes exactly 2048 cycles from the first valid cycle. `req_valid_o` never drops during a run.
- R10: After `done_o`, a new start begins a fresh run from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run when idle |
| done_o | output | 1 | One-cycle pulse after the final accepted address |
| req_addr_o | output | ADDR_W (10) | Word address of the current request |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Memory accepts the request |
| rd_data_i | input | ELEM_W*PACK (256) | Returned data word from memory |
| rd_valid_i | input | 1 | Returned word valid |
| rd_ready_o | output | 1 | Ready toward memory |
| dist_data_o | output | ELEM_W*PACK (256) | Data word toward the distributor chain |
| dist_valid_o | output | 1 | Word valid toward the chain |
| dist_ready_i | input | 1 | Chain accepts the word |

## Verification
The properties are checked on every cycle. They cover address stability under back-pressure, the start from idle, the one-cycle done pulse with the request port quiet, the range of the addresses, the continuous issue within a run, and an accept count of exactly 2048 whenever done fires. Only the bench scenarios can show the exact order of the addresses, the repetition across `t1`, that a start during a run is ignored, the 2048-cycle run under full ready, and a clean second run. The bench compares every accepted address against a reference model written from the requirement formula.

// File: rtl/tbag_pkg.sv
package tbag_pkg;

    localparam int NUM_LOOPS = 6;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_DONE = 2'd2
    } seq_state_e;

    // Counter width that holds the largest loop bound minus one.
    function automatic int dig_width(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return (m <= 2) ? 1 : $clog2(m);
    endfunction

    // Loop bound of nest level i (0 = outermost).
    function automatic int level_bound(input int i, input int outer_n, input int chain_n,
                                       input int row_n, input int col_n);
        if (i < 3)  return outer_n;
        if (i == 3) return chain_n;
        if (i == 4) return row_n;
        return col_n;
    endfunction

endpackage

// File: rtl/tbag_digit.sv
module tbag_digit #(
    parameter int LIMIT = 4,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    output logic [W-1:0] val,
    output logic         at_max
);
    assign at_max = (val == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            val <= '0;
        end else if (step) begin
            val <= at_max ? '0 : val + 1'b1;
        end
    end
endmodule

// File: rtl/tbag_loop_nest.sv
module tbag_loop_nest
    import tbag_pkg::*;
#(
    parameter int OUTER_N = 4,
    parameter int CHAIN_N = 2,
    parameter int ROW_N   = 8,
    parameter int COL_N   = 2,
    parameter int DIG_W   = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            clear,
    input  logic                            step,
    output logic [NUM_LOOPS-1:0][DIG_W-1:0] digits,
    output logic                            last
);
    logic [NUM_LOOPS-1:0] at_max;
    logic [NUM_LOOPS-1:0] carry;

    for (genvar i = 0; i < NUM_LOOPS; i++) begin : g_lvl
        localparam int LIM = level_bound(i, OUTER_N, CHAIN_N, ROW_N, COL_N);
        if (i == NUM_LOOPS - 1) begin : g_inner
            assign carry[i] = step;
        end else begin : g_outer
            // A level advances when every inner level wraps together.
            assign carry[i] = step & (&at_max[NUM_LOOPS-1:i+1]);
        end
        tbag_digit #(.LIMIT(LIM), .W(DIG_W)) u_dig (
            .clk   (clk),
            .rst   (rst),
            .clear (clear),
            .step  (carry[i]),
            .val   (digits[i]),
            .at_max(at_max[i])
        );
    end

    assign last = &at_max;
endmodule

// File: rtl/tbag_addr_calc.sv
module tbag_addr_calc
    import tbag_pkg::*;
#(
    parameter int DIG_W  = 3,
    parameter int ADDR_W = 10,
    parameter int W_T0   = 128,
    parameter int W_T1   = 0,
    parameter int W_T2   = 2,
    parameter int W_S    = 64,
    parameter int W_R    = 8,
    parameter int W_C    = 1
) (
    input  logic [NUM_LOOPS-1:0][DIG_W-1:0] digits,
    output logic [ADDR_W-1:0]               addr
);
    localparam int WT [NUM_LOOPS] = '{W_T0, W_T1, W_T2, W_S, W_R, W_C};

    always_comb begin
        addr = '0;
        for (int i = 0; i < NUM_LOOPS; i++) begin
            addr = addr + ADDR_W'(digits[i]) * ADDR_W'(WT[i]);
        end
    end
endmodule

// File: rtl/tbag_seq_ctrl.sv
module tbag_seq_ctrl
    import tbag_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic accept,
    input  logic last,
    output logic issue,
    output logic done,
    output logic clear
);
    seq_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        clear    = 1'b0;
        unique case (state)
            SEQ_IDLE: if (start) begin
                state_nx = SEQ_RUN;
                clear    = 1'b1;
            end
            SEQ_RUN:  if (accept && last) state_nx = SEQ_DONE;
            SEQ_DONE: state_nx = SEQ_IDLE;
            default:  state_nx = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SEQ_IDLE;
        else     state <= state_nx;
    end

    assign issue = (state == SEQ_RUN);
    assign done  = (state == SEQ_DONE);
endmodule

// File: rtl/tbag_top.sv
module tbag_top
    import tbag_pkg::*;
#(
    parameter int ELEM_W  = 32,
    parameter int PACK    = 8,
    parameter int OUTER_N = 4,
    parameter int CHAIN_N = 2,
    parameter int ROW_N   = 8,
    parameter int COL_N   = 2,
    parameter int W_T0    = 128,
    parameter int W_T1    = 0,
    parameter int W_T2    = 2,
    parameter int W_S     = 64,
    parameter int W_R     = 8,
    parameter int W_C     = 1,
    parameter int ADDR_W  = 10
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    output logic                     done_o,
    output logic [ADDR_W-1:0]        req_addr_o,
    output logic                     req_valid_o,
    input  logic                     req_ready_i,
    input  logic [ELEM_W*PACK-1:0]   rd_data_i,
    input  logic                     rd_valid_i,
    output logic                     rd_ready_o,
    output logic [ELEM_W*PACK-1:0]   dist_data_o,
    output logic                     dist_valid_o,
    input  logic                     dist_ready_i
);
    localparam int DIG_W       = dig_width(OUTER_N, CHAIN_N, ROW_N, COL_N);
    localparam int TOTAL_WORDS = OUTER_N * OUTER_N * OUTER_N * CHAIN_N * ROW_N * COL_N;
    localparam int MAX_ADDR    = W_T0 * (OUTER_N - 1) + W_T1 * (OUTER_N - 1)
                               + W_T2 * (OUTER_N - 1) + W_S * (CHAIN_N - 1)
                               + W_R * (ROW_N - 1) + W_C * (COL_N - 1);

    logic                            accept;
    logic                            last;
    logic                            clear;
    logic [NUM_LOOPS-1:0][DIG_W-1:0] digits;

    assign accept = req_valid_o & req_ready_i;

    tbag_seq_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start_i),
        .accept(accept),
        .last  (last),
        .issue (req_valid_o),
        .done  (done_o),
        .clear (clear)
    );

    tbag_loop_nest #(
        .OUTER_N(OUTER_N), .CHAIN_N(CHAIN_N), .ROW_N(ROW_N),
        .COL_N(COL_N), .DIG_W(DIG_W)
    ) u_nest (
        .clk   (clk),
        .rst   (rst),
        .clear (clear),
        .step  (accept),
        .digits(digits),
        .last  (last)
    );

    tbag_addr_calc #(
        .DIG_W(DIG_W), .ADDR_W(ADDR_W),
        .W_T0(W_T0), .W_T1(W_T1), .W_T2(W_T2),
        .W_S(W_S), .W_R(W_R), .W_C(W_C)
    ) u_addr (
        .digits(digits),
        .addr  (req_addr_o)
    );

    // Returned words go straight on to the distributor chain.
    assign dist_data_o  = rd_data_i;
    assign dist_valid_o = rd_valid_i;
    assign rd_ready_o   = dist_ready_i;
endmodule

// File: rtl/tbag_chk.sv
module tbag_chk #(
    parameter int ADDR_W   = 10,
    parameter int TOTAL    = 2048,
    parameter int MAX_ADDR = 511
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              done_o,
    input logic [ADDR_W-1:0] req_addr_o,
    input logic              req_valid_o,
    input logic              req_ready_i
);
    int acc_cnt;

    always_ff @(posedge clk) begin
        if (rst)                                     acc_cnt <= 0;
        else if (start_i && !req_valid_o && !done_o) acc_cnt <= 0;
        else if (req_valid_o && req_ready_i)         acc_cnt <= acc_cnt + 1;
    end

    assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (start_i && !req_valid_o && !done_o) |=> req_valid_o);

    assert_hold_on_stall_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !req_valid_o);

    assert_done_count_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (acc_cnt == TOTAL));

    assert_addr_range_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid_o |-> (req_addr_o <= ADDR_W'(MAX_ADDR)));

    assert_no_gap_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid_o && req_ready_i && (acc_cnt < TOTAL - 1)) |=> req_valid_o);
endmodule

bind tbag_top tbag_chk #(
    .ADDR_W(ADDR_W), .TOTAL(TOTAL_WORDS), .MAX_ADDR(MAX_ADDR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .done_o     (done_o),
    .req_addr_o (req_addr_o),
    .req_valid_o(req_valid_o),
    .req_ready_i(req_ready_i)
);

// File: tb/tb_tbag_top.sv
module tb_tbag_top;
    localparam int ADDR_W = 10;
    localparam int DW     = 256;
    localparam int TOTAL  = 2048;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              done_o;
    logic [ADDR_W-1:0] req_addr_o;
    logic              req_valid_o;
    logic              req_ready_i = 1'b0;
    logic [DW-1:0]     rd_data_i = '0;
    logic              rd_valid_i = 1'b0;
    logic              rd_ready_o;
    logic [DW-1:0]     dist_data_o;
    logic              dist_valid_o;
    logic              dist_ready_i = 1'b0;

    int checks = 0;
    int fails  = 0;
    int got_addr [TOTAL];

    tbag_top dut (
        .clk(clk), .rst(rst), .start_i(start_i), .done_o(done_o),
        .req_addr_o(req_addr_o), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
        .rd_data_i(rd_data_i), .rd_valid_i(rd_valid_i), .rd_ready_o(rd_ready_o),
        .dist_data_o(dist_data_o), .dist_valid_o(dist_valid_o), .dist_ready_i(dist_ready_i)
    );

    always #4 clk = ~clk;

    function automatic int exp_addr(input int k);
        int c, r, s, t2, t0, v;
        v  = k;
        c  = v % 2; v = v / 2;
        r  = v % 8; v = v / 8;
        s  = v % 2; v = v / 2;
        t2 = v % 4; v = v / 4;
        v  = v / 4;
        t0 = v;
        return 128 * t0 + 64 * s + 8 * r + 2 * t2 + c;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic pass_check(input string tag);
        rd_data_i    = {$urandom, $urandom, $urandom, $urandom,
                        $urandom, $urandom, $urandom, $urandom};
        rd_valid_i   = 1'($urandom);
        dist_ready_i = 1'($urandom);
        #1;
        chk(dist_data_o == rd_data_i, tag, longint'(dist_data_o[63:0]), longint'(rd_data_i[63:0]));
        chk(dist_valid_o == rd_valid_i && rd_ready_o == dist_ready_i, tag,
            {dist_valid_o, rd_ready_o}, {rd_valid_i, dist_ready_i});
    endtask

    // Runs one full sequence; returns cycles from first valid to last accept.
    task automatic run_seq(input int ready_pct, input bit poke, input string start_tag,
                           output int cycles);
        int k;
        string tag;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(req_valid_o == 1'b1, start_tag, req_valid_o, 1);
        chk(req_addr_o == 0, start_tag, req_addr_o, 0);
        k = 0;
        cycles = 0;
        while (k < TOTAL) begin
            req_ready_i = (($urandom % 100) < ready_pct);
            start_i     = (poke && k >= 700 && k < 703);
            chk(req_valid_o == 1'b1, "R9", req_valid_o, 1);
            if (req_valid_o && req_ready_i) begin
                tag = (poke && k >= 700 && k <= 708) ? "R6" : "R3";
                got_addr[k] = int'(req_addr_o);
                chk(int'(req_addr_o) == exp_addr(k), tag, req_addr_o, exp_addr(k));
                k++;
            end
            if ((cycles % 97) == 0) pass_check("R8");
            @(negedge clk);
            cycles++;
        end
        start_i     = 1'b0;
        req_ready_i = 1'b0;
        chk(done_o == 1'b1, "R5", done_o, 1);
        chk(req_valid_o == 1'b0, "R5", req_valid_o, 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R5", done_o, 0);
        chk(req_valid_o == 1'b0, "R5", req_valid_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        int unsigned seed;
        int cyc;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        chk(req_valid_o == 1'b0 && done_o == 1'b0, "R1", {req_valid_o, done_o}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_valid_o == 1'b0 && done_o == 1'b0, "R1", {req_valid_o, done_o}, 0);
        repeat (5) @(negedge clk);
        chk(req_valid_o == 1'b0, "R2", req_valid_o, 0);

        // Stall check at the start of a run.
        run_seq(50, 1'b1, "R2", cyc);

        // Repetition over the middle tile index.
        for (int k = 0; k < 128; k++) begin
            chk(got_addr[k] == got_addr[k + 128] && got_addr[k] == got_addr[k + 384],
                "R7", got_addr[k + 128], got_addr[k]);
        end
        for (int k = 512; k < 640; k++) begin
            chk(got_addr[k] == got_addr[k + 256], "R7", got_addr[k + 256], got_addr[k]);
        end

        // Second run at full throughput.
        run_seq(100, 1'b0, "R10", cyc);
        chk(cyc == TOTAL, "R9", cyc, TOTAL);

        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            pass_check("R8");
        end
        finish_run();
    end
endmodule